// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block gathers interrupt request lines from across the chip, grouped into banks of 32, and drives one interrupt output to a processor. Each request line has a pending flag. An enable bit passes the flag on and a mask bit blocks it. A source is *qualified* when its flag is pending, its enable bit is 1 and its mask bit is 0. The lowest-numbered qualified source is reported through a read-only vector register. Software reads that register, services the source, and reads the vector again until it returns zero.

Source 0 differs from the others. It is an external line with a selectable trigger type. Its pending flag latches, and software must clear it by writing a one to it. All other sources follow their input level, so no acknowledge is needed at the controller. The vector reads zero both when no source is qualified and when source 0 is the one selected. Software separates the two cases by reading bit 0 of the first pending bank.

The register port has a single write strobe. Read data is registered and always shows the word at the address that was presented in the previous cycle. Two small storage registers sit beside the live state: a protection flag and a bank of fast-path pending words.

Top module: `vec_intc`

## Requirements
- R1: Source n is held at bit n%32 of bank n/32. Pending words are at 0x10 + 4·bank. For sources 1 and above, the pending bit takes the input level on every clock unless a clear write to that bit lands in the same cycle.
- R2: The vector word at offset 0x00 returns the selected source number in bits [8:2]. Bits [1:0] and [31:9] read as zero. The word is 0 when no source is qualified.
- R3: When several sources are qualified, the vector selects the one with the lowest number.
- R4: Enable words are at 0x40 + 4·bank and reset to 0. An enable bit of 0 keeps its source out of the vector and off the interrupt output.
- R5: Mask words are at 0x50 + 4·bank and can be read and written. A mask bit of 1 keeps its source out of the vector and off the interrupt output.
- R6: `irq_out` is a register. It is 1 in the cycle after a cycle in which at least one source is qualified, and 0 otherwise.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. Writing all ones to a bank clears the whole bank.
- R8: The 2-bit trigger field of source 0 is at offset 0x0C. Its encodings are 0 = low level, 1 = high level, 2 = falling edge and 3 = rising edge. In the edge modes, only the selected edge sets the pending bit. Once set, the bit stays set until it is cleared by a write.
- R9: In the level modes, the pending bit of source 0 sets again on the next clock if the line is still at its active level when the clear is written.
- R10: The protection flag is bit 0 at offset 0x08. The fast-path pending words are at 0x20 + 4·bank. Both read back what was last written, and the flag keeps only bit 0.
- R11: Reads of unmapped offsets and of missing banks return 0. Writes to the vector word, to unmapped offsets and to missing banks change no state.
- R12: After reset, all pending, enable, mask and fast-path words are 0, and so are the protection flag, the trigger field and `irq_out`.
- R13: `bus_rdata` shows the word at the address presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_BANKS*32 | Request lines; bit 0 is the external line |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The bench targets the following corner cases:

- **Vector reads zero with source 0 pending and enabled.** A design that offset the index or set a valid bit would return a nonzero vector here.
- **Lowest number wins.** Sources 37 and 70 are both qualified, and later source 0 is qualified together with 70. A highest-first encoder would report the wrong number.
- **Edge modes respond to one edge only.** The bench drives the opposite edge in each edge mode, then checks that the flag stays latched after the line returns. A level-following source 0 would lose the flag.
- **Clears and unmapped addresses.** The bench writes zeros to pending words, clears a level source that is still active, and writes to the vector, unmapped and missing-bank addresses. Any of these that wrongly changed state shows up when the word is read back.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  // Register word width; one bank per word.
  localparam int DATA_W = 32;

  // Address regions (bits [7:4]) and word selects inside region 0.
  localparam logic [3:0] RGN_CTRL  = 4'h0;
  localparam logic [3:0] RGN_PEND  = 4'h1;
  localparam logic [3:0] RGN_FPEND = 4'h2;
  localparam logic [3:0] RGN_EN    = 4'h4;
  localparam logic [3:0] RGN_MSK   = 4'h5;

  localparam logic [1:0] SEL_VEC  = 2'd0;
  localparam logic [1:0] SEL_PROT = 2'd2;
  localparam logic [1:0] SEL_TRIG = 2'd3;

  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'd0,
    TRIG_LVL_HI    = 2'd1,
    TRIG_EDGE_FALL = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_e;
endpackage

// File: rtl/irqc_ext_trig.sv
module irqc_ext_trig
  import vec_intc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  line,
  input  trig_e mode,
  output logic  evt
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= line;
  end

  always_comb begin
    case (mode)
      TRIG_LVL_LO:    evt = ~line;
      TRIG_LVL_HI:    evt = line;
      TRIG_EDGE_FALL: evt = prev_q & ~line;
      default:        evt = ~prev_q & line;
    endcase
  end
endmodule

// File: rtl/irqc_pend_bank.sv
module irqc_pend_bank #(
  parameter int W       = 32,
  parameter bit HAS_EXT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lines,
  input  logic [W-1:0] clr,
  input  logic         ext_evt,
  output logic [W-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      pend[0] <= HAS_EXT ? ((pend[0] & ~clr[0]) | ext_evt) : (lines[0] & ~clr[0]);
      for (int i = 1; i < W; i++)
        pend[i] <= lines[i] & ~clr[i];
    end
  end

  generate
    if (HAS_EXT) begin : g_ext_chk
      // R7
      ext_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr[0] && !ext_evt) |=> !pend[0]);
      // R8
      ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend[0] && !clr[0]) |=> pend[0]);
    end
    for (genvar i = 1; i < W; i++) begin : g_lvl_chk
      // R1
      lvl_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (lines[i] && !clr[i]) |=> pend[i]);
    end
  endgenerate
endmodule

// File: rtl/irqc_lowest_pick.sv
module irqc_lowest_pick #(
  parameter int N  = 96,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_BANKS*DATA_W-1:0] irq_src,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      irq_out
);
  localparam int NSRC = NUM_BANKS * DATA_W;
  localparam int IW   = $clog2(NSRC);

  // Address decode: region in [7:4], bank/word in [3:2], [1:0] must be 0.
  logic [3:0] rgn;
  logic [1:0] bsel;
  logic       map_ok, bank_ok;
  assign rgn     = bus_addr[7:4];
  assign bsel    = bus_addr[3:2];
  assign map_ok  = ((bus_addr >> 8) == '0) && (bus_addr[1:0] == 2'b00);
  assign bank_ok = map_ok && (int'(bsel) < NUM_BANKS);

  logic [DATA_W-1:0] pend_q  [NUM_BANKS];
  logic [DATA_W-1:0] fpend_q [NUM_BANKS];
  logic [DATA_W-1:0] en_q    [NUM_BANKS];
  logic [DATA_W-1:0] msk_q   [NUM_BANKS];
  logic [NSRC-1:0]   pend_flat, en_flat, msk_flat, active;
  logic              prot_q;
  trig_e             trig_q;
  logic              ext_evt;

  // Control storage
  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q <= 1'b0;
      trig_q <= TRIG_LVL_LO;
    end else if (bus_wr && map_ok && rgn == RGN_CTRL) begin
      if (bsel == SEL_PROT) prot_q <= bus_wdata[0];
      if (bsel == SEL_TRIG) trig_q <= trig_e'(bus_wdata[1:0]);
    end
  end

  irqc_ext_trig u_ext (
    .clk  (clk),
    .rst  (rst),
    .line (irq_src[0]),
    .mode (trig_q),
    .evt  (ext_evt)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      logic [DATA_W-1:0] clr;
      assign hit = bus_wr && bank_ok && (int'(bsel) == b);
      assign clr = (hit && rgn == RGN_PEND) ? bus_wdata : '0;

      irqc_pend_bank #(.W(DATA_W), .HAS_EXT(b == 0)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .lines   (irq_src[b*DATA_W +: DATA_W]),
        .clr     (clr),
        .ext_evt (ext_evt),
        .pend    (pend_q[b])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          fpend_q[b] <= '0;
          en_q[b]    <= '0;
          msk_q[b]   <= '0;
        end else if (hit) begin
          if (rgn == RGN_FPEND) fpend_q[b] <= bus_wdata;
          if (rgn == RGN_EN)    en_q[b]    <= bus_wdata;
          if (rgn == RGN_MSK)   msk_q[b]   <= bus_wdata;
        end
      end

      assign pend_flat[b*DATA_W +: DATA_W] = pend_q[b];
      assign en_flat[b*DATA_W +: DATA_W]   = en_q[b];
      assign msk_flat[b*DATA_W +: DATA_W]  = msk_q[b];
    end
  endgenerate

  assign active = pend_flat & en_flat & ~msk_flat;

  logic          found;
  logic [IW-1:0] pick_idx;
  irqc_lowest_pick #(.N(NSRC)) u_pick (
    .req   (active),
    .found (found),
    .idx   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= found;
  end

  // Registered read mux
  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (map_ok && rgn == RGN_CTRL) begin
      case (bsel)
        SEL_VEC:  rd_next = found ? (DATA_W'(pick_idx) << 2) : '0;
        SEL_PROT: rd_next = DATA_W'(prot_q);
        SEL_TRIG: rd_next = DATA_W'(trig_q);
        default:  rd_next = '0;
      endcase
    end else if (bank_ok) begin
      case (rgn)
        RGN_PEND:  rd_next = pend_q[bsel];
        RGN_FPEND: rd_next = fpend_q[bsel];
        RGN_EN:    rd_next = en_q[bsel];
        RGN_MSK:   rd_next = msk_q[bsel];
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // Assertions
  logic [NSRC-1:0] below_mask;
  assign below_mask = (NSRC'(1) << pick_idx) - NSRC'(1);

  // R3
  pick_valid_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> active[pick_idx]);
  // R3
  pick_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> ((active & below_mask) == '0));
  // R4
  en_block_chk: assert property (@(posedge clk) disable iff (rst)
    (en_flat == '0) |=> !irq_out);
  // R5
  msk_block_chk: assert property (@(posedge clk) disable iff (rst)
    (&msk_flat) |=> !irq_out);
  // R2
  vec_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    (map_ok && rgn == RGN_CTRL && bsel == SEL_VEC)
      |=> (bus_rdata[1:0] == 2'b00 && (bus_rdata >> 9) == '0));
  // R8
  ext_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_q == TRIG_EDGE_RISE && $rose(irq_src[0])) |=> pend_q[0][0]);
endmodule

// File: tb/vec_intc_tb_top.sv
module vec_intc_tb_top;
  localparam int NB = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB*32-1:0] irq_src = '0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_out;

  always #5 clk = ~clk;

  vec_intc #(.NUM_BANKS(NB), .ADDR_W(8)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .irq_src   (irq_src),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  // Monitor: compare after the edge that registers the result
  initial begin
    forever begin
      exp_t e;
      wait (q.size() > 0);
      @(posedge clk);
      #2;
      e = q.pop_front();
      checks++;
      if (e.is_irq) begin
        if (irq_out !== e.val[0]) begin
          errors++;
          $display("FAIL %s irq_out actual=%0b expected=%0b", e.tag, irq_out, e.val[0]);
        end
      end else if (bus_rdata !== e.val) begin
        errors++;
        $display("FAIL %s rdata actual=%h expected=%h", e.tag, bus_rdata, e.val);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    q.push_back('{1'b0, exp, tag});
    @(posedge clk); #3;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(negedge clk);
    q.push_back('{1'b1, {31'b0, exp}, tag});
    @(posedge clk); #3;
  endtask

  task automatic set_src(input int n, input logic v);
    @(negedge clk);
    irq_src[n] = v;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    irq_src[0] = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    settle();

    // R12: reset state
    rd_chk(8'h40, 32'h0, "R12 enable reset");
    rd_chk(8'h50, 32'h0, "R12 mask reset");
    rd_chk(8'h10, 32'h0, "R12 pending reset");
    rd_chk(8'h08, 32'h0, "R12 protect reset");
    rd_chk(8'h0C, 32'h0, "R12 trigger reset");
    rd_chk(8'h00, 32'h0, "R12 vector reset");
    irq_chk(1'b0, "R12 irq reset");

    // R1 mapping, R4 enable gate
    set_src(37, 1'b1); settle();
    rd_chk(8'h14, 32'h20, "R1 source 37 bank1 bit5");
    irq_chk(1'b0, "R4 disabled no irq");
    rd_chk(8'h00, 32'h0, "R4 disabled no vector");
    wr(8'h44, 32'h20); settle();
    irq_chk(1'b1, "R6 irq on qualified");
    rd_chk(8'h00, 32'h94, "R2 vector 37<<2");

    // R5 mask
    wr(8'h54, 32'h20); settle();
    irq_chk(1'b0, "R5 masked no irq");
    rd_chk(8'h00, 32'h0, "R5 masked no vector");
    rd_chk(8'h54, 32'h20, "R5 mask readback");
    wr(8'h54, 32'h0); settle();

    // R3 lowest wins
    set_src(70, 1'b1);
    wr(8'h48, 32'h40); settle();
    rd_chk(8'h00, 32'h94, "R3 37 beats 70");
    set_src(37, 1'b0); settle();
    rd_chk(8'h00, 32'h118, "R3 70 alone");
    rd_chk(8'h14, 32'h0, "R1 pending follows level low");

    // R7 write zero no effect; level source re-sets
    wr(8'h18, 32'h0); settle();
    rd_chk(8'h18, 32'h40, "R7 write zero keeps pending");
    wr(8'h18, 32'hFFFF_FFFF); settle();
    rd_chk(8'h18, 32'h40, "R1 level source sets again after clear");
    set_src(70, 1'b0); settle();
    irq_chk(1'b0, "R6 irq drops");

    // R8 rising edge
    wr(8'h0C, 32'h3); settle();
    set_src(0, 1'b0); settle();
    rd_chk(8'h10, 32'h0, "R8 falling ignored in rise mode");
    set_src(0, 1'b1); settle();
    set_src(0, 1'b0); settle();
    rd_chk(8'h10, 32'h1, "R8 rise latched after line drops");
    wr(8'h40, 32'h1); settle();
    irq_chk(1'b1, "R6 irq from source 0");
    rd_chk(8'h00, 32'h0, "R2 vector zero for source 0");
    wr(8'h10, 32'h0); settle();
    rd_chk(8'h10, 32'h1, "R7 zero write leaves source 0");
    wr(8'h10, 32'h1); settle();
    rd_chk(8'h10, 32'h0, "R7 one write clears source 0");
    irq_chk(1'b0, "R7 irq gone after clear");

    // R8 falling edge
    wr(8'h0C, 32'h2); settle();
    set_src(0, 1'b1); settle();
    rd_chk(8'h10, 32'h0, "R8 rising ignored in fall mode");
    set_src(0, 1'b0); settle();
    rd_chk(8'h10, 32'h1, "R8 fall latched");
    wr(8'h10, 32'hFFFF_FFFF); settle();
    rd_chk(8'h10, 32'h0, "R7 all ones clears bank");

    // R9 high level
    wr(8'h0C, 32'h1); settle();
    set_src(0, 1'b1); settle();
    rd_chk(8'h10, 32'h1, "R8 high level sets");
    wr(8'h10, 32'h1); settle();
    rd_chk(8'h10, 32'h1, "R9 still high sets again");
    set_src(0, 1'b0);
    wr(8'h10, 32'h1); settle();
    rd_chk(8'h10, 32'h0, "R9 clear sticks once line idle");

    // R8 low level, R3 source 0 beats 70
    set_src(70, 1'b1);
    wr(8'h0C, 32'h0); settle();
    rd_chk(8'h10, 32'h1, "R8 low level sets");
    rd_chk(8'h00, 32'h0, "R3 source 0 beats 70");
    irq_chk(1'b1, "R6 irq with two sources");
    set_src(0, 1'b1);
    wr(8'h10, 32'h1); settle();
    rd_chk(8'h00, 32'h118, "R3 70 after source 0 cleared");
    set_src(70, 1'b0); settle();

    // R10 storage
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk(8'h08, 32'h1, "R10 protect keeps bit 0");
    wr(8'h0C, 32'hFFFF_FFFE);
    rd_chk(8'h0C, 32'h2, "R10 trigger field readback");
    wr(8'h24, 32'hA5A5_A5A5);
    rd_chk(8'h24, 32'hA5A5_A5A5, "R10 fast pending storage");

    // R11 ignored writes and unmapped reads
    wr(8'h00, 32'hFFFF_FFFF); settle();
    rd_chk(8'h00, 32'h0, "R11 vector write ignored");
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk(8'h04, 32'h0, "R11 unmapped word reads zero");
    wr(8'h4C, 32'hFFFF_FFFF);
    rd_chk(8'h4C, 32'h0, "R11 missing bank reads zero");
    rd_chk(8'h40, 32'h1, "R11 enable bank0 unchanged");
    rd_chk(8'h48, 32'h40, "R11 enable bank2 unchanged");
    wr(8'h30, 32'hFFFF_FFFF);
    rd_chk(8'h30, 32'h0, "R11 unmapped region reads zero");
    irq_chk(1'b0, "R11 no irq after ignored writes");
    rd_chk(8'h14, 32'h0, "R13 read one cycle after address");

    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule